// File: doc/BRIEF.md
# CAN Receive Bit Sampling Front End

This block sits between the CAN transceiver pins and the protocol engine of a CAN controller. It picks one of two clock-enable sources (bus or oscillator) and divides it into time quanta with a programmable prescaler. It counts quanta through each bit time: a one-quantum sync segment, then a programmable first phase segment ending at the sample point, then a programmable second phase segment. At the sample point it decides the received bit, either from that single quantum sample or from a majority vote over the sample point and the two quanta before it. It then hands the bit to the engine with a one-clock strobe.

For self test, a loop-back setting feeds the engine's transmit bitstream straight into the sampler. The receive pin is ignored and the transmit pin is held recessive. During the acknowledge slot the sampled value is replaced by a dominant bit. While the bus is idle, a recessive-to-dominant edge on the effective input restarts bit timing at the sync segment. Configuration writes are gated by controller mode. The clock source accepts a write only in disable mode. Sampling mode, loop-back and timing fields accept a write only in freeze mode.

Top module: `can_bit_frontend`

## Requirements
- R1: The quantum prescaler advances on `bus_ce` when the clock-source setting is 1 and on `osc_ce` when it is 0. After reset the setting is 0 (oscillator).
- R2: A write to the clock-source setting takes effect only while `mode_disable` is 1. At any other time it is ignored.
- R3: With prescaler setting P (0..255), one time quantum lasts P+1 selected clock enables. Quantum boundaries occur on the enable that finds the prescaler count at or above P.
- R4: A bit time is quantum index 0 (sync), then indices 1..S1+1, then S2+1 more quanta, where S1 and S2 are the segment settings. The sample point is the end of quantum index S1+1. After the last index the count returns to 0.
- R5: With the sampling-mode setting at 0, the decided bit equals the effective input sampled at the end of the sample-point quantum.
- R6: With the sampling-mode setting at 1, the decided bit is the majority of the effective input at the ends of the sample-point quantum and the two quanta before it.
- R7: Writes to sampling mode, loop-back, prescaler and segment settings take effect only while `mode_freeze` is 1. At any other time they are ignored.
- R8: With loop-back at 1, the effective input is `tx_bit`, `rx_pin` is ignored and `tx_pin` is 1. With loop-back at 0, the effective input is `rx_pin` and `tx_pin` follows `tx_bit`.
- R9: With loop-back at 1, a bit decided while `ack_slot` is 1 is reported as 0 (dominant).
- R10: When `bus_idle` is 1 and the effective input goes from 1 to 0 between two clocks, the prescaler and the quantum index restart at 0 and no quantum boundary occurs in that clock.
- R11: `rx_valid` is 1 for exactly the clock after each sample-point boundary, and `rx_bit` holds the decided value from then on. After reset `rx_valid` is 0 and `rx_bit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_ce | input | 1 | Clock enable derived from the bus clock |
| osc_ce | input | 1 | Clock enable derived from the oscillator clock |
| mode_freeze | input | 1 | Controller is in freeze mode |
| mode_disable | input | 1 | Controller is in disable mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_src | input | 1 | Clock-source value to write (1 bus, 0 oscillator) |
| cfg_triple | input | 1 | Sampling-mode value to write (1 majority of three) |
| cfg_loop | input | 1 | Loop-back value to write |
| cfg_presc | input | PRESC_W | Prescaler value to write |
| cfg_seg1 | input | SEG1_W | First phase segment value to write |
| cfg_seg2 | input | SEG2_W | Second phase segment value to write |
| tx_bit | input | 1 | Transmit bitstream from the protocol engine |
| ack_slot | input | 1 | Engine marks the acknowledge slot |
| bus_idle | input | 1 | Engine reports the bus idle |
| rx_pin | input | 1 | Receive pin from the transceiver |
| tx_pin | output | 1 | Transmit pin to the transceiver |
| rx_bit | output | 1 | Decided received bit |
| rx_valid | output | 1 | One-clock strobe per decided bit |

## Verification
The receive input is driven as runs of random length with frequent one-clock glitches. Under single sampling the glitches show up at the sample point, and under majority sampling they are outvoted. Comparing the two modes on the same pattern therefore separates the sampling rules. Bus and oscillator enables are driven with different rates, so a wrong clock-source selection shifts every strobe. Loop-back runs drive `rx_pin` and `tx_bit` independently with acknowledge pulses, which exposes any leak from the pin or a missing dominant override. Idle-bus phases with falling edges at arbitrary times test the timing restart. Configuration writes are issued both inside and outside the permitted modes, and an accepted stray write shows up as a change in bit timing or decisions.

// File: rtl/can_fe_pkg.sv
package can_fe_pkg;

    typedef enum logic {
        SRC_OSC = 1'b0,
        SRC_BUS = 1'b1
    } clk_src_e;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/can_fe_cfg.sv
module can_fe_cfg
    import can_fe_pkg::*;
#(
    parameter int PRESC_W  = 8,
    parameter int SEG1_W   = 4,
    parameter int SEG2_W   = 3,
    parameter int SEG1_RST = 3,
    parameter int SEG2_RST = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_freeze,
    input  logic                mode_disable,
    input  logic                we,
    input  logic                w_src,
    input  logic                w_triple,
    input  logic                w_loop,
    input  logic [PRESC_W-1:0]  w_presc,
    input  logic [SEG1_W-1:0]   w_seg1,
    input  logic [SEG2_W-1:0]   w_seg2,
    output clk_src_e            src,
    output logic                triple,
    output logic                loop,
    output logic [PRESC_W-1:0]  presc,
    output logic [SEG1_W-1:0]   seg1,
    output logic [SEG2_W-1:0]   seg2
);

    typedef struct packed {
        clk_src_e              src;
        logic                  triple;
        logic                  loop;
        logic [PRESC_W-1:0]    presc;
        logic [SEG1_W-1:0]     seg1;
        logic [SEG2_W-1:0]     seg2;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we && mode_disable) begin
            cfg_d.src = clk_src_e'(w_src);
        end
        if (we && mode_freeze) begin
            cfg_d.triple = w_triple;
            cfg_d.loop   = w_loop;
            cfg_d.presc  = w_presc;
            cfg_d.seg1   = w_seg1;
            cfg_d.seg2   = w_seg2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.src    <= SRC_OSC;
            cfg_q.triple <= 1'b0;
            cfg_q.loop   <= 1'b0;
            cfg_q.presc  <= '0;
            cfg_q.seg1   <= SEG1_W'(SEG1_RST);
            cfg_q.seg2   <= SEG2_W'(SEG2_RST);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign src    = cfg_q.src;
    assign triple = cfg_q.triple;
    assign loop   = cfg_q.loop;
    assign presc  = cfg_q.presc;
    assign seg1   = cfg_q.seg1;
    assign seg2   = cfg_q.seg2;

    AST_SRC_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_disable |=> $stable(src)); // R2

    AST_FREEZE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_freeze |=> ($stable(triple) && $stable(loop) && $stable(presc)
                          && $stable(seg1) && $stable(seg2))); // R7

endmodule

// File: rtl/can_fe_tq.sv
module can_fe_tq #(
    parameter int PRESC_W = 8,
    parameter int SEG1_W  = 4,
    parameter int SEG2_W  = 3,
    parameter int QW      = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [PRESC_W-1:0]  presc,
    input  logic [SEG1_W-1:0]   seg1,
    input  logic [SEG2_W-1:0]   seg2,
    input  logic                eff_rx,
    input  logic                bus_idle,
    output logic                tq_en,
    output logic                at_sp,
    output logic [QW-1:0]       q_idx
);

    typedef struct packed {
        logic [PRESC_W-1:0] pre;
        logic [QW-1:0]      q;
        logic               prev;
    } tq_t;

    tq_t st_d, st_q;
    logic          sync_req;
    logic [QW-1:0] sp_idx;
    logic [QW-1:0] last_idx;

    always_comb begin
        sp_idx   = QW'(seg1) + QW'(1);
        last_idx = QW'(seg1) + QW'(seg2) + QW'(2);
        sync_req = bus_idle && st_q.prev && !eff_rx;
        tq_en    = tick && !sync_req && (st_q.pre >= presc);
        at_sp    = tq_en && (st_q.q == sp_idx);

        st_d      = st_q;
        st_d.prev = eff_rx;
        if (sync_req) begin
            st_d.pre = '0;
            st_d.q   = '0;
        end else if (tq_en) begin
            st_d.pre = '0;
            st_d.q   = (st_q.q >= last_idx) ? '0 : st_q.q + QW'(1);
        end else if (tick) begin
            st_d.pre = st_q.pre + PRESC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pre  <= '0;
            st_q.q    <= '0;
            st_q.prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_idx = st_q.q;

    AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_idle && !eff_rx && st_q.prev) |=> (q_idx == '0 && st_q.pre == '0)); // R10

    AST_PRESC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !sync_req) |=> $stable(q_idx)); // R3

endmodule

// File: rtl/can_fe_sampler.sv
module can_fe_sampler
    import can_fe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tq_en,
    input  logic at_sp,
    input  logic eff_rx,
    input  logic triple,
    input  logic ack_force,
    output logic rx_bit,
    output logic rx_valid
);

    typedef struct packed {
        logic [1:0] hist;
        logic       bit_v;
        logic       vld;
    } smp_t;

    smp_t s_d, s_q;
    logic decided;

    always_comb begin
        decided = triple ? vote3(s_q.hist[1], s_q.hist[0], eff_rx) : eff_rx;
        if (ack_force) begin
            decided = 1'b0;
        end

        s_d     = s_q;
        s_d.vld = 1'b0;
        if (tq_en) begin
            s_d.hist = {s_q.hist[0], eff_rx};
        end
        if (at_sp) begin
            s_d.bit_v = decided;
            s_d.vld   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.hist  <= 2'b11;
            s_q.bit_v <= 1'b1;
            s_q.vld   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rx_bit   = s_q.bit_v;
    assign rx_valid = s_q.vld;

    AST_SINGLE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (at_sp && !triple && !ack_force) |=> (rx_bit == $past(eff_rx))); // R5

    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !at_sp |=> $stable(rx_bit)); // R11

endmodule

// File: rtl/can_bit_frontend.sv
module can_bit_frontend
    import can_fe_pkg::*;
#(
    parameter int PRESC_W  = 8,
    parameter int SEG1_W   = 4,
    parameter int SEG2_W   = 3,
    parameter int SEG1_RST = 3,
    parameter int SEG2_RST = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_ce,
    input  logic               osc_ce,
    input  logic               mode_freeze,
    input  logic               mode_disable,
    input  logic               cfg_we,
    input  logic               cfg_src,
    input  logic               cfg_triple,
    input  logic               cfg_loop,
    input  logic [PRESC_W-1:0] cfg_presc,
    input  logic [SEG1_W-1:0]  cfg_seg1,
    input  logic [SEG2_W-1:0]  cfg_seg2,
    input  logic               tx_bit,
    input  logic               ack_slot,
    input  logic               bus_idle,
    input  logic               rx_pin,
    output logic               tx_pin,
    output logic               rx_bit,
    output logic               rx_valid
);

    localparam int QW = $clog2((2 ** SEG1_W) + (2 ** SEG2_W) + 1);

    clk_src_e           src_sel;
    logic               triple_on;
    logic               loop_on;
    logic [PRESC_W-1:0] presc_v;
    logic [SEG1_W-1:0]  seg1_v;
    logic [SEG2_W-1:0]  seg2_v;
    logic               tick;
    logic               eff_rx;
    logic               tq_en;
    logic               at_sp;
    logic [QW-1:0]      q_idx;
    logic               ack_force;

    can_fe_cfg #(
        .PRESC_W(PRESC_W), .SEG1_W(SEG1_W), .SEG2_W(SEG2_W),
        .SEG1_RST(SEG1_RST), .SEG2_RST(SEG2_RST)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .mode_freeze(mode_freeze), .mode_disable(mode_disable),
        .we(cfg_we), .w_src(cfg_src), .w_triple(cfg_triple), .w_loop(cfg_loop),
        .w_presc(cfg_presc), .w_seg1(cfg_seg1), .w_seg2(cfg_seg2),
        .src(src_sel), .triple(triple_on), .loop(loop_on),
        .presc(presc_v), .seg1(seg1_v), .seg2(seg2_v)
    );

    always_comb begin
        tick      = (src_sel == SRC_BUS) ? bus_ce : osc_ce;
        eff_rx    = loop_on ? tx_bit : rx_pin;
        tx_pin    = loop_on ? 1'b1 : tx_bit;
        ack_force = loop_on && ack_slot;
    end

    can_fe_tq #(
        .PRESC_W(PRESC_W), .SEG1_W(SEG1_W), .SEG2_W(SEG2_W), .QW(QW)
    ) u_tq (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .presc(presc_v), .seg1(seg1_v), .seg2(seg2_v),
        .eff_rx(eff_rx), .bus_idle(bus_idle),
        .tq_en(tq_en), .at_sp(at_sp), .q_idx(q_idx)
    );

    can_fe_sampler u_smp (
        .clk(clk), .rst_n(rst_n), .tq_en(tq_en), .at_sp(at_sp),
        .eff_rx(eff_rx), .triple(triple_on), .ack_force(ack_force),
        .rx_bit(rx_bit), .rx_valid(rx_valid)
    );

    AST_VALID_AT_SP: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(at_sp)); // R11

    AST_ACK_DOMINANT: assert property (@(posedge clk) disable iff (!rst_n)
        (at_sp && loop_on && ack_slot) |=> (rx_valid && !rx_bit)); // R9

    AST_SP_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        at_sp |-> (q_idx == QW'(seg1_v) + QW'(1))); // R4

endmodule

// File: tb/test_can_bit_frontend.sv
module test_can_bit_frontend;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_ce = 1'b0, osc_ce = 1'b0;
    logic       mode_freeze = 1'b0, mode_disable = 1'b0;
    logic       cfg_we = 1'b0, cfg_src = 1'b0, cfg_triple = 1'b0, cfg_loop = 1'b0;
    logic [7:0] cfg_presc = '0;
    logic [3:0] cfg_seg1 = '0;
    logic [2:0] cfg_seg2 = '0;
    logic       tx_bit = 1'b1, ack_slot = 1'b0, bus_idle = 1'b0, rx_pin = 1'b1;
    logic       tx_pin, rx_bit, rx_valid;

    can_bit_frontend i_can_bit_frontend (
        .clk(clk), .rst_n(rst_n), .bus_ce(bus_ce), .osc_ce(osc_ce),
        .mode_freeze(mode_freeze), .mode_disable(mode_disable),
        .cfg_we(cfg_we), .cfg_src(cfg_src), .cfg_triple(cfg_triple), .cfg_loop(cfg_loop),
        .cfg_presc(cfg_presc), .cfg_seg1(cfg_seg1), .cfg_seg2(cfg_seg2),
        .tx_bit(tx_bit), .ack_slot(ack_slot), .bus_idle(bus_idle), .rx_pin(rx_pin),
        .tx_pin(tx_pin), .rx_bit(rx_bit), .rx_valid(rx_valid)
    );

    always #4 clk = ~clk;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;
    string req = "R11";

    // behavioural reference state
    int m_pre, m_q, m_presc, m_seg1, m_seg2;
    bit m_src, m_triple, m_loop, m_prev, h0, h1;
    bit exp_valid, exp_bit;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_q = 0; m_presc = 0; m_seg1 = 3; m_seg2 = 2;
            m_src = 0; m_triple = 0; m_loop = 0; m_prev = 1; h0 = 1; h1 = 1;
            exp_valid = 0; exp_bit = 1;
        end else begin
            bit eff, tick, sync;
            eff  = m_loop ? tx_bit : rx_pin;
            tick = m_src ? bus_ce : osc_ce;
            sync = bus_idle && m_prev && !eff;
            exp_valid = 0;
            if (sync) begin
                m_pre = 0; m_q = 0;
            end else if (tick) begin
                if (m_pre >= m_presc) begin
                    m_pre = 0;
                    if (m_q == m_seg1 + 1) begin
                        exp_valid = 1;
                        if (m_triple) exp_bit = (int'(h1) + int'(h0) + int'(eff)) >= 2;
                        else          exp_bit = eff;
                        if (m_loop && ack_slot) exp_bit = 0;
                    end
                    h1 = h0; h0 = eff;
                    m_q = (m_q >= m_seg1 + m_seg2 + 2) ? 0 : m_q + 1;
                end else begin
                    m_pre++;
                end
            end
            m_prev = eff;
            if (cfg_we && mode_disable) m_src = cfg_src;
            if (cfg_we && mode_freeze) begin
                m_triple = cfg_triple; m_loop = cfg_loop;
                m_presc = cfg_presc; m_seg1 = cfg_seg1; m_seg2 = cfg_seg2;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            fails++;
            $display("FAIL watchdog: run did not end (act=%0d cycles exp<190000)", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic compare();
        vectors++;
        if (rx_valid !== exp_valid) begin
            fails++;
            $display("FAIL %s rx_valid act=%0b exp=%0b t=%0t", req, rx_valid, exp_valid, $time);
        end else if (rx_valid && rx_bit !== exp_bit) begin
            fails++;
            $display("FAIL %s rx_bit act=%0b exp=%0b t=%0t", req, rx_bit, exp_bit, $time);
        end
        if (tx_pin !== (m_loop ? 1'b1 : tx_bit)) begin
            fails++;
            $display("FAIL %s R8 tx_pin act=%0b exp=%0b", req, tx_pin, m_loop ? 1'b1 : tx_bit);
        end
    endtask

    // phase knobs
    bit k_src = 0, k_triple = 0, k_loop = 0, k_glitch = 0, k_idle = 0, k_ack = 0;
    bit k_frz = 0, k_dis = 0, k_modejit = 0;
    int k_wrate = 0;
    int hold_rx = 0, hold_tx = 0;

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
            bus_ce = ($urandom % 3) == 0;
            osc_ce = ($urandom % 2) == 0;
            mode_freeze  = k_modejit ? (($urandom % 2) == 0) : k_frz;
            mode_disable = k_modejit ? (($urandom % 2) == 0) : k_dis;
            cfg_we = (k_wrate != 0) && (($urandom % k_wrate) == 0);
            cfg_src    = k_modejit ? 1'($urandom) : k_src;
            cfg_triple = k_modejit ? 1'($urandom) : k_triple;
            cfg_loop   = k_modejit ? 1'($urandom) : k_loop;
            cfg_presc  = 8'($urandom % 3);
            cfg_seg1   = 4'(1 + $urandom % 5);
            cfg_seg2   = 3'($urandom % 4);
            if (hold_rx == 0) begin
                rx_pin  = ~rx_pin;
                hold_rx = (k_glitch && ($urandom % 3 == 0)) ? 1 : 6 + $urandom % 30;
            end else hold_rx--;
            if (hold_tx == 0) begin
                tx_bit  = ~tx_bit;
                hold_tx = (k_glitch && ($urandom % 3 == 0)) ? 1 : 6 + $urandom % 30;
            end else hold_tx--;
            ack_slot = k_ack && (($urandom % 8) == 0);
            bus_idle = k_idle && (($urandom % 4) != 0);
        end
    endtask

    task automatic set_cfg(input bit src, input bit tri_on, input bit lp);
        k_src = src; k_triple = tri_on; k_loop = lp;
        k_modejit = 0; k_frz = 1; k_dis = 1; k_wrate = 1;
        run(4);
        k_frz = 0; k_dis = 0; k_wrate = 40;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        req = "R11";
        compare();  // reset state: rx_valid 0, tx_pin follows tx_bit
        rst_n = 1'b1;

        req = "R1 R3 R5";
        set_cfg(0, 0, 0);
        run(4000);

        req = "R1 bus";
        set_cfg(1, 0, 0);
        run(4000);

        req = "R2";
        k_modejit = 1; k_wrate = 5;
        run(4000);

        req = "R5 glitch";
        k_modejit = 0; k_glitch = 1;
        set_cfg(0, 0, 0);
        run(5000);

        req = "R6";
        set_cfg(0, 1, 0);
        run(6000);

        req = "R7";
        k_modejit = 1; k_wrate = 7;
        run(4000);

        req = "R4";
        k_modejit = 0; k_glitch = 0;
        set_cfg(1, 0, 0);
        k_wrate = 3; k_frz = 1;
        run(5000);

        req = "R8 R9";
        k_frz = 0; k_ack = 1; k_glitch = 1;
        set_cfg(0, 1, 1);
        run(6000);
        set_cfg(1, 0, 1);
        run(4000);

        req = "R10";
        k_ack = 0; k_idle = 1;
        set_cfg(0, 0, 0);
        run(5000);
        set_cfg(1, 1, 1);
        run(4000);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule